// File: doc/BRIEF.md
# Oversampled Serial Receive Channel with Error Flags

This block receives asynchronous serial characters on a single line. It samples the line once per pulse of a sample enable that runs at sixteen times the bit rate. It waits for the line to go low, confirms the start bit at its middle, and then takes one sample from the centre of every later bit. Each character has eight data bits sent least significant bit first, an optional even or odd parity bit, and one or two stop bits. The assembled character is shifted into an internal shift register.

When a character ends, the block decides how to handle it. The character is either copied into the data register that the CPU reads, or held back. The block also sets four status flags: data-full, overrun, framing error and parity error. The decision depends on which errors occurred in that character. The CPU reads the byte with a read strobe, which clears data-full. It clears the three error flags with separate clear strobes. A line held low (a break) shows up as a framing error with a zero byte, and the condition repeats for as long as the line stays low.

Top module: `async_serial_rx`

## Requirements
- R1: In idle, the first sample-enable pulse that sees the synchronised line low starts a character. If the line is high again eight pulses later, at the middle of the start bit, the character is dropped and no flag or register changes.
- R2: After a confirmed start, each later bit is sampled every sixteen pulses. Eight data bits are assembled least significant bit first. A character with no error and no overrun is copied into the data register and sets data-full.
- R3: par_sel[1]=1 adds a parity bit after the data bits. par_sel[0]=0 selects even parity and par_sel[0]=1 selects odd parity. Even parity means the data bits plus the parity bit hold an even number of ones. A mismatch sets the parity flag. With par_sel[1]=0 there is no parity bit and the parity flag is never set.
- R4: stop2=1 selects two stop bits and stop2=0 selects one. Any stop bit sampled low sets the framing flag.
- R5: A character with a framing error, a parity error or both, and no overrun, is still copied into the data register. The matching flags are set and data-full is not set.
- R6: An overrun occurs when a character completes while data-full is still set and no read happens in that cycle. On an overrun the overrun flag is set, any framing or parity flags that apply are also set, the data register keeps its old byte, and data-full stays 1.
- R7: A line held low produces a framing error with 0x00 in the data register. Reception continues, so after the framing flag is cleared the next character time raises it again.
- R8: data_rd clears data-full. A read in the same cycle that a character completes counts as done first, so that character causes no overrun.
- R9: clr_ovr, clr_frm and clr_par each clear their flag. When a flag is being set in the same cycle as its clear, the set wins.
- R10: During and after reset, the data register reads 0x00 and all four flags read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rx_line | input | 1 | Serial receive line, idle high |
| par_sel | input | 2 | Bit 1 enables parity; bit 0 selects odd (1) or even (0) |
| stop2 | input | 1 | 1 selects two stop bits, 0 selects one |
| data_rd | input | 1 | CPU read strobe for the data register; clears data-full |
| clr_ovr | input | 1 | Clear strobe for the overrun flag |
| clr_frm | input | 1 | Clear strobe for the framing flag |
| clr_par | input | 1 | Clear strobe for the parity flag |
| rx_data | output | 8 | Data register |
| st_full | output | 1 | Data-full flag |
| st_ovr | output | 1 | Overrun flag |
| st_frm | output | 1 | Framing error flag |
| st_par | output | 1 | Parity error flag |

## Verification
A character can complete in the same clock cycle as a CPU strobe. Two such collisions matter:
- A read colliding with completion decides between an overrun and a clean hand-over.
- A flag clear colliding with completion decides whether a fresh error survives.

To provoke each case, the bench's reference model announces the cycle in which the next sample pulse will end the character, and the bench fires the strobe in exactly that cycle. In the read case it expects no overrun, the new byte in the data register and data-full set. In the clear case it expects the framing flag still set after the edge.

// File: rtl/async_rx_pkg.sv
`timescale 1ns/1ps
package async_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP1,
    RX_STOP2
  } rx_state_e;

  // Number of sample pulses from the start detection up to and including
  // the pulse that samples the last stop bit.
  function automatic int frame_ticks(input int osr, input int dw,
                                     input logic pen, input logic two);
    return osr / 2 + osr * (dw + (pen ? 1 : 0) + 1 + (two ? 1 : 0));
  endfunction

  // Value the parity bit must carry for a given xor of the data bits.
  function automatic logic parity_want(input logic data_xor, input logic odd);
    return data_xor ^ odd;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
`timescale 1ns/1ps
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= 1'b1;
        else        ff_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= {ff_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/rx_frame_ctrl.sv
`timescale 1ns/1ps
module rx_frame_ctrl
  import async_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_en,
  input  logic          rx_s,
  input  logic [1:0]    par_sel,
  input  logic          stop2,
  output logic          frame_done,
  output logic [DW-1:0] byte_o,
  output logic          ferr_o,
  output logic          perr_o
);

  localparam int CNT_W  = $clog2(OSR);
  localparam int IDX_W  = (DW > 1) ? $clog2(DW) : 1;
  localparam int SPAN_W = $clog2(frame_ticks(OSR, DW, 1'b1, 1'b1) + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] TOP  = IDX_W'(DW - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    sh_q;
  logic             par_bad_q;
  logic             stop_bad_q;

  logic bit_end;
  logic par_expect;

  assign bit_end    = samp_en && (cnt_q == LAST);
  assign par_expect = parity_want(^sh_q, par_sel[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      sh_q       <= '0;
      par_bad_q  <= 1'b0;
      stop_bad_q <= 1'b0;
    end else if (samp_en) begin
      case (state_q)
        RX_IDLE: begin
          if (!rx_s) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
        end
        RX_START: begin
          if (cnt_q == MID) begin
            cnt_q <= '0;
            if (rx_s) begin
              state_q <= RX_IDLE;
            end else begin
              state_q    <= RX_DATA;
              idx_q      <= '0;
              par_bad_q  <= 1'b0;
              stop_bad_q <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            sh_q  <= {rx_s, sh_q[DW-1:1]};
            if (idx_q == TOP) state_q <= par_sel[1] ? RX_PAR : RX_STOP1;
            else              idx_q   <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (cnt_q == LAST) begin
            cnt_q     <= '0;
            par_bad_q <= (rx_s != par_expect);
            state_q   <= RX_STOP1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP1: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            if (stop2) begin
              stop_bad_q <= !rx_s;
              state_q    <= RX_STOP2;
            end else begin
              state_q <= RX_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP2: begin
          if (cnt_q == LAST) begin
            cnt_q   <= '0;
            state_q <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  // End-of-character event and its verdicts, valid in the same cycle.
  assign frame_done = bit_end &&
                      ((state_q == RX_STOP1 && !stop2) || state_q == RX_STOP2);
  assign ferr_o     = !rx_s || ((state_q == RX_STOP2) && stop_bad_q);
  assign perr_o     = par_bad_q;
  assign byte_o     = sh_q;

  // Independent span counter: pulses since the start detection.
  logic [SPAN_W-1:0] span_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               span_q <= '0;
    else if (samp_en) begin
      if (state_q == RX_IDLE) span_q <= '0;
      else                    span_q <= span_q + 1'b1;
    end
  end

  AST_FRAME_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (span_q == SPAN_W'(frame_ticks(OSR, DW, par_sel[1], stop2) - 1))); // R2

  AST_NO_PARITY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !par_sel[1]) |-> !perr_o); // R3

  AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (state_q == RX_IDLE)); // R4

endmodule

// File: rtl/rx_status_bank.sv
`timescale 1ns/1ps
module rx_status_bank #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_done,
  input  logic [DW-1:0] byte_i,
  input  logic          ferr_i,
  input  logic          perr_i,
  input  logic          data_rd,
  input  logic          clr_ovr,
  input  logic          clr_frm,
  input  logic          clr_par,
  output logic [DW-1:0] rx_data,
  output logic          st_full,
  output logic          st_ovr,
  output logic          st_frm,
  output logic          st_par
);

  logic [DW-1:0] data_q;
  logic full_q, ovr_q, frm_q, par_q;

  // Named per-character events.
  logic ovr_evt;
  logic xfer_evt;
  logic clean;
  logic frm_set;
  logic par_set;

  assign ovr_evt  = frame_done && full_q && !data_rd;
  assign xfer_evt = frame_done && !ovr_evt;
  assign clean    = !ferr_i && !perr_i;
  assign frm_set  = frame_done && ferr_i;
  assign par_set  = frame_done && perr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      if (xfer_evt) data_q <= byte_i;

      if (xfer_evt && clean) full_q <= 1'b1;
      else if (data_rd)      full_q <= 1'b0;

      if (ovr_evt)      ovr_q <= 1'b1;
      else if (clr_ovr) ovr_q <= 1'b0;

      if (frm_set)      frm_q <= 1'b1;
      else if (clr_frm) frm_q <= 1'b0;

      if (par_set)      par_q <= 1'b1;
      else if (clr_par) par_q <= 1'b0;
    end
  end

  assign rx_data = data_q;
  assign st_full = full_q;
  assign st_ovr  = ovr_q;
  assign st_frm  = frm_q;
  assign st_par  = par_q;

  AST_CLEAN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !ferr_i && !perr_i && !st_full) |=> (st_full && rx_data == $past(byte_i))); // R2

  AST_ERR_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && (ferr_i || perr_i) && !ovr_evt) |=> (!st_full && rx_data == $past(byte_i))); // R5

  AST_OVR_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ($stable(rx_data) && st_full && st_ovr)); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !frame_done) |=> !st_full); // R8

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && ferr_i && clr_frm) |=> st_frm); // R9

endmodule

// File: rtl/async_serial_rx.sv
`timescale 1ns/1ps
module async_serial_rx #(
  parameter int OSR         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_en,
  input  logic          rx_line,
  input  logic [1:0]    par_sel,
  input  logic          stop2,
  input  logic          data_rd,
  input  logic          clr_ovr,
  input  logic          clr_frm,
  input  logic          clr_par,
  output logic [DW-1:0] rx_data,
  output logic          st_full,
  output logic          st_ovr,
  output logic          st_frm,
  output logic          st_par
);

  logic          rx_s;
  logic          frame_done;
  logic [DW-1:0] byte_w;
  logic          ferr_w;
  logic          perr_w;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_line),
    .q     (rx_s)
  );

  rx_frame_ctrl #(.OSR(OSR), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_en    (samp_en),
    .rx_s       (rx_s),
    .par_sel    (par_sel),
    .stop2      (stop2),
    .frame_done (frame_done),
    .byte_o     (byte_w),
    .ferr_o     (ferr_w),
    .perr_o     (perr_w)
  );

  rx_status_bank #(.DW(DW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .byte_i     (byte_w),
    .ferr_i     (ferr_w),
    .perr_i     (perr_w),
    .data_rd    (data_rd),
    .clr_ovr    (clr_ovr),
    .clr_frm    (clr_frm),
    .clr_par    (clr_par),
    .rx_data    (rx_data),
    .st_full    (st_full),
    .st_ovr     (st_ovr),
    .st_frm     (st_frm),
    .st_par     (st_par)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!st_full && !st_ovr && !st_frm && !st_par)); // R10

endmodule

// File: tb/tb_async_serial_rx.sv
`timescale 1ns/1ps
module tb_async_serial_rx;

  localparam int BT = 64;  // clocks per bit: 16 pulses, one every 4 clocks

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, rx_line, stop2, data_rd, clr_ovr, clr_frm, clr_par;
  logic [1:0] par_sel;
  logic       samp_en;
  logic [7:0] rx_data;
  logic       st_full, st_ovr, st_frm, st_par;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  assign samp_en = ((cyc % 4) == 3);

  int n_run = 0;
  int n_bad = 0;
  bit finished = 0;

  async_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rx_line(rx_line),
    .par_sel(par_sel), .stop2(stop2), .data_rd(data_rd),
    .clr_ovr(clr_ovr), .clr_frm(clr_frm), .clr_par(clr_par),
    .rx_data(rx_data), .st_full(st_full), .st_ovr(st_ovr),
    .st_frm(st_frm), .st_par(st_par)
  );

  task automatic expect_eq(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       h1, h2;
  int       mn;
  bit       mbusy;
  bit [7:0] msh;
  bit       mp, msb;
  bit       mfull, movr, mfrm, mpar;
  bit [7:0] mdata;
  bit       m_due;

  function automatic int span_end();
    return 8 + 16 * (8 + (par_sel[1] ? 1 : 0) + (stop2 ? 2 : 1));
  endfunction

  always @(posedge clk) begin : mdl
    bit v, done, fe, pe, oe;
    int k;
    if (!rst_n) begin
      h1 = 1; h2 = 1; mbusy = 0; mn = 0; msh = 0; mp = 0; msb = 0;
      mfull = 0; movr = 0; mfrm = 0; mpar = 0; mdata = 0; m_due = 0;
    end else begin
      v = h2; h2 = h1; h1 = rx_line;
      done = 0; fe = 0; pe = 0;
      if (samp_en) begin
        if (!mbusy) begin
          if (!v) begin mbusy = 1; mn = 0; end
        end else begin
          mn++;
          if (mn == 8) begin
            if (v) mbusy = 0; else msb = 0;
          end else if (mn > 8 && ((mn - 8) % 16) == 0) begin
            k = (mn - 8) / 16;
            if (k <= 8) msh[k-1] = v;
            else if (par_sel[1] && k == 9) mp = v;
            else if (!v) msb = 1;
            if (mn == span_end()) begin
              done = 1; mbusy = 0; fe = msb;
              pe = par_sel[1] && (mp != ((^msh) ^ par_sel[0]));
            end
          end
        end
      end
      oe = done && mfull && !data_rd;
      if (data_rd) mfull = 0;
      if (done && !oe) begin
        mdata = msh;
        if (!fe && !pe) mfull = 1;
      end
      if (clr_ovr) movr = 0;
      if (oe) movr = 1;
      if (clr_frm) mfrm = 0;
      if (done && fe) mfrm = 1;
      if (clr_par) mpar = 0;
      if (done && pe) mpar = 1;
      m_due = mbusy && (mn + 1 == span_end());
    end
  end

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      expect_eq("R2 data vs model", int'(rx_data), int'(mdata));
      expect_eq("R8 full vs model", int'(st_full), int'(mfull));
      expect_eq("R6 overrun vs model", int'(st_ovr), int'(movr));
      expect_eq("R4 framing vs model", int'(st_frm), int'(mfrm));
      expect_eq("R3 parity vs model", int'(st_par), int'(mpar));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hold(input bit v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input bit [7:0] b, input bit bad_par, input bit [1:0] bad_stop);
    hold(0, BT);
    for (int i = 0; i < 8; i++) hold(b[i], BT);
    if (par_sel[1]) hold(((^b) ^ par_sel[0]) ^ bad_par, BT);
    if (bad_stop[0]) begin hold(0, 40); hold(1, BT - 40); end
    else hold(1, BT);
    if (stop2) begin
      if (bad_stop[1]) begin hold(0, 40); hold(1, BT - 40); end
      else hold(1, BT);
    end
    hold(1, 2 * BT);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: data_rd = 1;
      1: clr_ovr = 1;
      2: clr_frm = 1;
      default: clr_par = 1;
    endcase
    @(negedge clk);
    data_rd = 0; clr_ovr = 0; clr_frm = 0; clr_par = 0;
    @(negedge clk);
  endtask

  // Fire a strobe in the very cycle the character completes.
  task automatic send_collide(input bit [7:0] b, input bit [1:0] bad_stop, input int which);
    fork
      send(b, 0, bad_stop);
      begin : watch
        while (!(m_due && samp_en)) @(negedge clk);
        if (which == 0) data_rd = 1; else clr_frm = 1;
        @(negedge clk);
        data_rd = 0; clr_frm = 0;
      end
    join
  endtask

  task automatic chk_out(input string tag, input bit [7:0] d, input bit f,
                         input bit o, input bit fr, input bit p);
    expect_eq({tag, " data"}, int'(rx_data), int'(d));
    expect_eq({tag, " full"}, int'(st_full), int'(f));
    expect_eq({tag, " overrun"}, int'(st_ovr), int'(o));
    expect_eq({tag, " framing"}, int'(st_frm), int'(fr));
    expect_eq({tag, " parity"}, int'(st_par), int'(p));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_bad++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    bit [7:0] d0;
    rst_n = 0; rx_line = 1; par_sel = 2'b00; stop2 = 0;
    data_rd = 0; clr_ovr = 0; clr_frm = 0; clr_par = 0;
    repeat (5) @(negedge clk);
    chk_out("R10 in reset", 8'h00, 0, 0, 0, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_out("R10 after reset", 8'h00, 0, 0, 0, 0);

    // R2 / R3: clean character, par_sel=01 counts as no parity
    par_sel = 2'b01; stop2 = 0;
    send(8'hA5, 0, 2'b00);
    chk_out("R2 clean A5", 8'hA5, 1, 0, 0, 0);
    pulse(0);
    chk_out("R8 read clears full", 8'hA5, 0, 0, 0, 0);

    // R3: even parity correct
    par_sel = 2'b10;
    send(8'h3C, 0, 2'b00);
    chk_out("R3 even ok", 8'h3C, 1, 0, 0, 0);
    pulse(0);

    // R3 / R4: odd parity, two stop bits
    par_sel = 2'b11; stop2 = 1;
    send(8'h81, 0, 2'b00);
    chk_out("R4 odd two-stop ok", 8'h81, 1, 0, 0, 0);
    pulse(0);

    // R5: parity error transfers without full
    par_sel = 2'b10; stop2 = 0;
    send(8'h5A, 1, 2'b00);
    chk_out("R5 parity error", 8'h5A, 0, 0, 0, 1);
    pulse(3);
    chk_out("R9 clear parity", 8'h5A, 0, 0, 0, 0);

    // R4 / R5: bad single stop bit
    par_sel = 2'b00;
    send(8'h77, 0, 2'b01);
    chk_out("R5 framing error", 8'h77, 0, 0, 1, 0);
    pulse(2);

    // R4: second of two stop bits low
    stop2 = 1;
    send(8'h66, 0, 2'b10);
    chk_out("R4 second stop low", 8'h66, 0, 0, 1, 0);
    pulse(2);
    stop2 = 0;

    // R6: overrun, then overrun plus framing
    send(8'h11, 0, 2'b00);
    chk_out("R6 first byte", 8'h11, 1, 0, 0, 0);
    send(8'h22, 0, 2'b00);
    chk_out("R6 overrun", 8'h11, 1, 1, 0, 0);
    send(8'h33, 0, 2'b01);
    chk_out("R6 overrun with framing", 8'h11, 1, 1, 1, 0);
    pulse(0);
    chk_out("R8 read after overrun", 8'h11, 0, 1, 1, 0);
    pulse(1);
    pulse(2);
    chk_out("R9 clears", 8'h11, 0, 0, 0, 0);

    // R7: line break
    hold(0, 11 * BT);
    chk_out("R7 break", 8'h00, 0, 0, 1, 0);
    clr_frm = 1; @(negedge clk); clr_frm = 0;
    hold(0, 11 * BT);
    chk_out("R7 break repeats", 8'h00, 0, 0, 1, 0);
    hold(1, 12 * BT);
    pulse(0); pulse(1); pulse(2); pulse(3);

    // R1: glitch rejected
    d0 = rx_data;
    hold(0, 8);
    hold(1, 2 * BT);
    chk_out("R1 glitch ignored", d0, 0, 0, 0, 0);
    send(8'h96, 0, 2'b00);
    chk_out("R1 recovers", 8'h96, 1, 0, 0, 0);

    // R8: read in the completion cycle beats overrun
    send_collide(8'h4B, 2'b00, 0);
    chk_out("R8 read at completion", 8'h4B, 1, 0, 0, 0);
    pulse(0);

    // R9: set beats clear in the same cycle
    send_collide(8'hC3, 2'b01, 1);
    chk_out("R9 set beats clear", 8'hC3, 0, 0, 1, 0);
    pulse(2);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

endmodule